// File: doc/BRIEF.md
# Counter Slot Allocator with Group Exclusion

This block hands out performance-counter slots to event requests. Each request carries an event identifier whose low nibble names an event group and whose next eight bits name the event code inside that group. A general event is granted the lowest-numbered free general counter, but only if no other live event already occupies the same group. The allocator tracks which slots and which groups are in use and remembers the group of every live general slot, so a release needs only the slot number.

One reserved identifier, 0xFE, asks for the dedicated cycle counter, which is the highest slot index. It bypasses the group check and never alters the group bitmap. Malformed identifiers are refused with a distinct reject flag. Every accepted request receives exactly one registered response one clock later. A release may arrive in the same cycle as a request.

Top module: `ctr_slot_alloc`

## Requirements
- R1: After reset, no response is valid and the slot bitmap `used_slots` and group bitmap `used_groups` are all zero.
- R2: A request sampled at a clock edge produces `rsp_valid` high after that same edge for exactly one cycle. A cycle with no request produces `rsp_valid` low.
- R3: A well-formed general request takes the lowest-numbered free slot among slots 0..EVT_CTRS-1 and never the cycle slot. It sets that slot's bit in `used_slots` and sets bit `req_event[3:0]` in `used_groups`.
- R4: When all general slots are in use, a general request is answered with `rsp_grant` low and leaves both bitmaps unchanged.
- R5: When the request's group bit is already set, the request is answered with `rsp_grant` low even if a general slot is free.
- R6: Identifier 0xFE is granted slot index EVT_CTRS (8 by default) when that slot is free, and is otherwise answered busy. It never changes `used_groups`.
- R7: An identifier other than 0xFE is rejected when any bit from 12 upward is set or when the group nibble is NUM_GROUPS or more. A rejected request gives `rsp_reject` high, `rsp_grant` low and no bitmap change.
- R8: A release of an allocated general slot clears its slot bit and the bit of the group it was granted with. A release of the allocated cycle slot clears only its slot bit.
- R9: A release of a free slot, or of an index above EVT_CTRS, changes neither bitmap.
- R10: When a request and a release occur in the same cycle, the request is decided on the state before the release, and then both updates are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted every cycle |
| req_event | input | 16 | Event identifier: group in [3:0], code in [11:4], upper bits must be zero |
| rel_valid | input | 1 | Release strobe |
| rel_slot | input | 4 | Slot index to free |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_grant | output | 1 | 1 = slot granted, 0 = busy or rejected |
| rsp_reject | output | 1 | Request identifier was malformed |
| rsp_slot | output | 4 | Granted slot index (0 when not granted) |
| used_slots | output | 9 | Slot occupancy bitmap, cycle slot in the top bit |
| used_groups | output | 8 | Group occupancy bitmap |

## Verification
Directed sequences exercise the allocator in turn with a free general slot and a fresh group, with a reused group while slots remain, with every general slot filled, with the cycle code twice in a row, and with several malformed identifiers. These patterns separate a group conflict from slot exhaustion, and separate a busy result from a reject. Releases of free, out-of-range, general and cycle slots show which bitmap bits each one clears. A request paired with a release of the same group shows whether the decision uses the state before or after the release. A long seeded random mix of all of these is then checked against a bench model of the bitmaps and of the group remembered for each slot.

// File: rtl/ctr_slot_alloc_pkg.sv
package ctr_slot_alloc_pkg;

    localparam int          CODE_BITS  = 12;
    localparam int          GROUP_BITS = 4;
    localparam logic [7:0]  CYCLE_CODE = 8'hFE;

    typedef enum logic [1:0] {
        KIND_GENERAL = 2'd0,
        KIND_CYCLE   = 2'd1,
        KIND_BAD     = 2'd2
    } req_kind_e;

endpackage

// File: rtl/ctr_slot_alloc_decode.sv
module ctr_slot_alloc_decode
    import ctr_slot_alloc_pkg::*;
#(
    parameter int ID_W       = 16,
    parameter int NUM_GROUPS = 8,
    localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
    input  logic [ID_W-1:0]  event_id,
    output req_kind_e        kind,
    output logic [GRP_W-1:0] group
);

    logic [GROUP_BITS-1:0] nibble;
    logic                  upper_set;

    assign nibble = event_id[GROUP_BITS-1:0];
    assign group  = nibble[GRP_W-1:0];

    always_comb begin
        upper_set = 1'b0;
        for (int b = CODE_BITS; b < ID_W; b++) begin
            if (event_id[b]) upper_set = 1'b1;
        end
    end

    always_comb begin
        if (!upper_set && event_id[CODE_BITS-1:8] == '0 && event_id[7:0] == CYCLE_CODE) begin
            kind = KIND_CYCLE;
        end else if (upper_set || ({1'b0, nibble} >= (GROUP_BITS+1)'(NUM_GROUPS))) begin
            kind = KIND_BAD;
        end else begin
            kind = KIND_GENERAL;
        end
    end

endmodule

// File: rtl/ctr_slot_alloc_pick.sv
module ctr_slot_alloc_pick #(
    parameter int N     = 8,
    parameter int OUT_W = 4
) (
    input  logic [N-1:0]     busy,
    output logic             found,
    output logic [OUT_W-1:0] index
);

    always_comb begin
        found = 1'b0;
        index = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                index = OUT_W'(i);
            end
        end
    end

endmodule

// File: rtl/ctr_slot_alloc.sv
module ctr_slot_alloc
    import ctr_slot_alloc_pkg::*;
#(
    parameter int  EVT_CTRS   = 8,
    parameter int  NUM_GROUPS = 8,
    parameter int  ID_W       = 16,
    localparam int NUM_SLOTS  = EVT_CTRS + 1,
    localparam int IDX_W      = $clog2(NUM_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ID_W-1:0]       req_event,
    input  logic                  rel_valid,
    input  logic [IDX_W-1:0]      rel_slot,
    output logic                  rsp_valid,
    output logic                  rsp_grant,
    output logic                  rsp_reject,
    output logic [IDX_W-1:0]      rsp_slot,
    output logic [NUM_SLOTS-1:0]  used_slots,
    output logic [NUM_GROUPS-1:0] used_groups
);

    localparam int GRP_W  = $clog2(NUM_GROUPS);
    localparam int CYC_IX = EVT_CTRS;

    typedef struct packed {
        logic [NUM_SLOTS-1:0]            slots;
        logic [NUM_GROUPS-1:0]           groups;
        logic [EVT_CTRS-1:0][GRP_W-1:0]  slot_grp;
        logic                            valid;
        logic                            grant;
        logic                            reject;
        logic [IDX_W-1:0]                idx;
    } state_t;

    state_t s_q, s_d;

    req_kind_e        kind;
    logic [GRP_W-1:0] req_grp;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             rel_ok;

    ctr_slot_alloc_decode #(
        .ID_W       (ID_W),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_decode (
        .event_id (req_event),
        .kind     (kind),
        .group    (req_grp)
    );

    ctr_slot_alloc_pick #(
        .N     (EVT_CTRS),
        .OUT_W (IDX_W)
    ) u_pick (
        .busy  (s_q.slots[EVT_CTRS-1:0]),
        .found (free_found),
        .index (free_idx)
    );

    assign rel_ok = rel_valid
                 && ({1'b0, rel_slot} < (IDX_W+1)'(NUM_SLOTS))
                 && s_q.slots[rel_slot];

    always_comb begin
        s_d        = s_q;
        s_d.valid  = req_valid;
        s_d.grant  = 1'b0;
        s_d.reject = 1'b0;
        s_d.idx    = '0;

        // release, judged on the registered state
        if (rel_ok) begin
            s_d.slots[rel_slot] = 1'b0;
            for (int i = 0; i < EVT_CTRS; i++) begin
                if (rel_slot == IDX_W'(i)) begin
                    s_d.groups[s_q.slot_grp[i]] = 1'b0;
                end
            end
        end

        // request, also judged on the registered state
        if (req_valid) begin
            unique case (kind)
                KIND_BAD: begin
                    s_d.reject = 1'b1;
                end
                KIND_CYCLE: begin
                    if (!s_q.slots[CYC_IX]) begin
                        s_d.grant         = 1'b1;
                        s_d.idx           = IDX_W'(CYC_IX);
                        s_d.slots[CYC_IX] = 1'b1;
                    end
                end
                default: begin
                    if (free_found && !s_q.groups[req_grp]) begin
                        s_d.grant             = 1'b1;
                        s_d.idx               = free_idx;
                        s_d.slots[free_idx]   = 1'b1;
                        s_d.groups[req_grp]   = 1'b1;
                        for (int i = 0; i < EVT_CTRS; i++) begin
                            if (free_idx == IDX_W'(i)) s_d.slot_grp[i] = req_grp;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid   = s_q.valid;
    assign rsp_grant   = s_q.grant;
    assign rsp_reject  = s_q.reject;
    assign rsp_slot    = s_q.idx;
    assign used_slots  = s_q.slots;
    assign used_groups = s_q.groups;

endmodule

// File: rtl/ctr_slot_alloc_chk.sv
module ctr_slot_alloc_chk #(
    parameter int  EVT_CTRS   = 8,
    parameter int  NUM_GROUPS = 8,
    parameter int  ID_W       = 16,
    localparam int NUM_SLOTS  = EVT_CTRS + 1,
    localparam int IDX_W      = $clog2(NUM_SLOTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [ID_W-1:0]       req_event,
    input logic                  rel_valid,
    input logic [IDX_W-1:0]      rel_slot,
    input logic                  rsp_valid,
    input logic                  rsp_grant,
    input logic                  rsp_reject,
    input logic [IDX_W-1:0]      rsp_slot,
    input logic [NUM_SLOTS-1:0]  used_slots,
    input logic [NUM_GROUPS-1:0] used_groups
);

    logic is_cyc_req;
    logic is_gen_req;

    assign is_cyc_req = req_valid && (req_event == ID_W'(8'hFE));
    assign is_gen_req = req_valid && (req_event[ID_W-1:12] == '0)
                     && ({1'b0, req_event[3:0]} < 5'(NUM_GROUPS));

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_grant_marks_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> used_slots[rsp_slot]);

    p_groups_match_slots_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(used_groups) == $countones(used_slots[EVT_CTRS-1:0]));

    p_full_is_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_gen_req && (&used_slots[EVT_CTRS-1:0])) |=> (rsp_valid && !rsp_grant));

    p_cycle_keeps_groups_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cyc_req && !rel_valid) |=> $stable(used_groups));

    p_reject_not_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> (rsp_valid && !rsp_grant));

endmodule

bind ctr_slot_alloc ctr_slot_alloc_chk #(
    .EVT_CTRS   (EVT_CTRS),
    .NUM_GROUPS (NUM_GROUPS),
    .ID_W       (ID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_event   (req_event),
    .rel_valid   (rel_valid),
    .rel_slot    (rel_slot),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .rsp_reject  (rsp_reject),
    .rsp_slot    (rsp_slot),
    .used_slots  (used_slots),
    .used_groups (used_groups)
);

// File: tb/test_ctr_slot_alloc.sv
`timescale 1ns/1ps
module test_ctr_slot_alloc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_event = '0;
    logic        rel_valid = 1'b0;
    logic [3:0]  rel_slot = '0;
    logic        rsp_valid, rsp_grant, rsp_reject;
    logic [3:0]  rsp_slot;
    logic [8:0]  used_slots;
    logic [7:0]  used_groups;

    int n_cmp = 0;
    int n_bad = 0;

    logic [8:0] m_slots = '0;
    logic [7:0] m_groups = '0;
    logic [2:0] m_sg [8];

    always #2 clk = ~clk;

    ctr_slot_alloc i_ctr_slot_alloc (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_event(req_event),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reject(rsp_reject),
        .rsp_slot(rsp_slot), .used_slots(used_slots), .used_groups(used_groups)
    );

    task automatic compare(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit id_bad(input logic [15:0] id);
        return (id[15:12] != 4'h0) || (id[3:0] > 4'd7);
    endfunction

    function automatic int lowest_free(input logic [8:0] s);
        for (int i = 0; i < 8; i++) if (!s[i]) return i;
        return -1;
    endfunction

    task automatic step(input bit rv, input logic [15:0] id, input bit lv,
                        input logic [3:0] ls, input string tag);
        bit e_grant = 0, e_rej = 0;
        int e_idx = 0;
        int f;
        logic [8:0] pre_s = m_slots;
        logic [7:0] pre_g = m_groups;
        if (rv) begin
            if (id == 16'h00FE) begin
                if (!pre_s[8]) begin e_grant = 1; e_idx = 8; end
            end else if (id_bad(id)) begin
                e_rej = 1;
            end else begin
                f = lowest_free(pre_s);
                if (f >= 0 && !pre_g[id[2:0]]) begin e_grant = 1; e_idx = f; end
            end
        end
        if (lv && ls <= 4'd8 && pre_s[ls]) begin
            m_slots[ls] = 1'b0;
            if (ls != 4'd8) m_groups[m_sg[ls[2:0]]] = 1'b0;
        end
        if (e_grant) begin
            m_slots[e_idx] = 1'b1;
            if (e_idx != 8) begin
                m_groups[id[2:0]] = 1'b1;
                m_sg[e_idx] = id[2:0];
            end
        end
        req_valid = rv; req_event = id; rel_valid = lv; rel_slot = ls;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; rel_valid = 1'b0;
        compare(tag, "rsp_valid", int'(rsp_valid), int'(rv));
        compare(tag, "rsp_grant", int'(rsp_grant), int'(e_grant));
        compare(tag, "rsp_reject", int'(rsp_reject), int'(e_rej));
        if (e_grant) compare(tag, "rsp_slot", int'(rsp_slot), e_idx);
        compare(tag, "used_slots", int'(used_slots), int'(m_slots));
        compare(tag, "used_groups", int'(used_groups), int'(m_groups));
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_sg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare("R1", "rsp_valid", int'(rsp_valid), 0);
        compare("R1", "used_slots", int'(used_slots), 0);
        compare("R1", "used_groups", int'(used_groups), 0);

        step(1, 16'h0010, 0, 0, "R3 first grant");
        step(1, 16'h0020, 0, 0, "R5 group taken");
        step(1, 16'h0031, 0, 0, "R3 second slot");
        step(0, 16'h0000, 0, 0, "R2 idle");
        step(1, 16'h00FE, 0, 0, "R6 cycle grant");
        step(1, 16'h00FE, 0, 0, "R6 cycle busy");
        step(1, 16'h01F8, 0, 0, "R7 group too big");
        step(1, 16'h1012, 0, 0, "R7 upper bit");
        step(1, 16'h00FF, 0, 0, "R7 near cycle code");
        step(0, 16'h0000, 1, 4'd5, "R9 free slot");
        step(0, 16'h0000, 1, 4'd12, "R9 out of range");
        step(0, 16'h0000, 1, 4'd0, "R8 general release");
        step(0, 16'h0000, 1, 4'd8, "R8 cycle release");
        step(1, 16'h0041, 1, 4'd1, "R10 same cycle");
        step(1, 16'h0041, 0, 0, "R10 after release");
        for (int g = 0; g < 8; g++) step(1, 16'(g + 16'h0050), 0, 0, "R3 fill");
        step(1, 16'h0063, 0, 0, "R4 all full");
        step(1, 16'h00FE, 0, 0, "R6 cycle while full");

        for (int n = 0; n < 600; n++) begin
            int sel = $urandom % 10;
            logic [15:0] id;
            bit rv = ($urandom % 4) != 0;
            bit lv = ($urandom % 5) < 2;
            logic [3:0] ls = 4'($urandom % 11);
            if (sel == 0)      id = 16'h00FE;
            else if (sel == 1) id = ($urandom % 2) ? {4'($urandom % 15 + 1), 12'($urandom)}
                                                   : {4'h0, 8'($urandom), 1'b1, 3'($urandom)};
            else               id = {4'h0, 8'($urandom), 1'b0, 3'($urandom)};
            step(rv, id, lv, ls, "R3 R5 R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule